// File: doc/BRIEF.md
# Test-Port Data Register Bank

This block is the data-register half of a boundary-scan test port. It holds three serial registers behind one scan output: a 32-bit identification register that reports a fixed device code, a single-bit pass-through register, and a boundary chain that samples and drives a parameterised number of general-purpose pins and also samples the chip reset pin. An external TAP controller supplies the capture, shift and update strobes, and an external instruction register supplies a two-bit select that picks the active register. Both of those sit outside this block.

Each register loads its capture value on a capture strobe and shifts one bit per rising test-clock edge while the shift strobe is high. New data enters at the most significant end and leaves at bit 0. The scan output is re-timed on the falling edge. The boundary chain has a second stage of update latches. These present test drive values (pin output and pin output-enable) and change only on an update strobe. Pin data can therefore stream through the chain without disturbing the pins.

Top module: `jtag_dr_bank`

## Requirements
- R1: A capture while the identification register is selected loads 0x1BA00477. The fields are version 1 in bits 31:28, part 0xBA00 in bits 27:12, maker 0x23B in bits 11:1, and bit 0 is always 1.
- R2: Select code 2'b00 picks the identification register, which is also the select value a reset instruction register holds. After reset the identification shift stage already holds the code. On the first falling edge after reset the scan output is 1, and shifting without a capture reads out 0x1BA00477.
- R3: The pass-through register captures 0. During shifting the scan output is the scan input delayed by one test-clock cycle.
- R4: Select 2'b01 picks the pass-through register and 2'b10 the boundary chain. The unassigned code 2'b11 acts exactly like 2'b01.
- R5: The boundary chain is 3*N+1 bits long. For chain slot k, bit 3k samples the pin input, bit 3k+1 the core output value and bit 3k+2 the core output enable. Bit 3N samples the reset pin input, and that pin has no other cell.
- R6: With REVERSE_PIN_ORDER=0, slot k serves pin k. With REVERSE_PIN_ORDER=1, slot k serves pin N-1-k.
- R7: Shifting moves every register toward bit 0 on the rising test-clock edge, with the scan input entering the top bit. The scan output changes on the falling edge and shows bit 0 of the selected register.
- R8: Drive outputs change only on an update strobe while the boundary chain is selected. They keep their value while the chain shifts and when an update strobe comes under any other select.
- R9: An update copies slot k's output cell (bit 3k+1) to that slot's pin drive value and its enable cell (bit 3k+2) to the pin drive enable.
- R10: When capture and shift are both high at one edge, the capture takes effect and no shift happens.
- R11: Synchronous active-high reset clears the drive outputs, the scan output, the pass-through bit and the boundary shift stage.
- R12: A register that is not selected ignores capture and shift strobes and keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| dr_sel | input | 2 | Data register select from the instruction decode |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output, falling-edge timed |
| pin_in | input | N_PINS | Sampled pin input values |
| core_out | input | N_PINS | Core-side output values to sample |
| core_oe | input | N_PINS | Core-side output enables to sample |
| rst_pin_in | input | 1 | Chip reset pin value to sample |
| drive_out | output | N_PINS | Update-latch pin drive values |
| drive_oe | output | N_PINS | Update-latch pin drive enables |

## Verification
Capture and shift can both be asserted at the same rising edge. The bench provokes this by raising both strobes together on the first edge of a boundary scan, then checks that the serial stream begins with the freshly sampled pin values and not with a shifted copy of the old contents. The second overlap is shifting new data through the chain while the update latches hold earlier drive values. The bench judges this by comparing the drive outputs with the previously updated pattern after a full scan that ends without an update, and again after an update strobe issued under a non-boundary select.

// File: rtl/jtag_dr_pkg.sv
package jtag_dr_pkg;

  typedef enum logic [1:0] {
    DRSEL_IDENT    = 2'b00,
    DRSEL_PASS     = 2'b01,
    DRSEL_BOUNDARY = 2'b10,
    DRSEL_SPARE    = 2'b11
  } drsel_e;

  localparam logic [3:0]  IDC_VERSION = 4'h1;
  localparam logic [15:0] IDC_PART    = 16'hBA00;
  localparam logic [10:0] IDC_MAKER   = 11'h23B;

  function automatic logic [31:0] idc_pack(input logic [3:0] ver,
                                           input logic [15:0] part,
                                           input logic [10:0] maker);
    return {ver, part, maker, 1'b1};
  endfunction

endpackage

// File: rtl/jtag_idcode_dr.sv
module jtag_idcode_dr #(
  parameter int          WIDTH = 32,
  parameter logic [31:0] CODE  = 32'h0000_0001
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             sel_en,
  input  logic             capture,
  input  logic             shift,
  input  logic             tdi,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge tck) begin
    if (rst)                    q <= CODE[WIDTH-1:0];
    else if (sel_en && capture) q <= CODE[WIDTH-1:0];
    else if (sel_en && shift)   q <= {tdi, q[WIDTH-1:1]};
  end
endmodule

// File: rtl/jtag_pass_dr.sv
module jtag_pass_dr (
  input  logic tck,
  input  logic rst,
  input  logic sel_en,
  input  logic capture,
  input  logic shift,
  input  logic tdi,
  output logic q
);
  always_ff @(posedge tck) begin
    if (rst)                    q <= 1'b0;
    else if (sel_en && capture) q <= 1'b0;
    else if (sel_en && shift)   q <= tdi;
  end
endmodule

// File: rtl/jtag_bscan_chain.sv
module jtag_bscan_chain #(
  parameter int N_PINS            = 4,
  parameter bit REVERSE_PIN_ORDER = 1'b0,
  localparam int CHAIN_LEN        = 3 * N_PINS + 1
) (
  input  logic                 tck,
  input  logic                 rst,
  input  logic                 sel_en,
  input  logic                 capture,
  input  logic                 shift,
  input  logic                 update,
  input  logic                 tdi,
  input  logic [N_PINS-1:0]    pin_in,
  input  logic [N_PINS-1:0]    core_out,
  input  logic [N_PINS-1:0]    core_oe,
  input  logic                 rst_pin_in,
  output logic [CHAIN_LEN-1:0] q,
  output logic [N_PINS-1:0]    drive_out,
  output logic [N_PINS-1:0]    drive_oe
);
  logic [CHAIN_LEN-1:0] cap_vec;

  assign cap_vec[CHAIN_LEN-1] = rst_pin_in;

  for (genvar k = 0; k < N_PINS; k++) begin : g_slot
    localparam int PIN = REVERSE_PIN_ORDER ? (N_PINS - 1 - k) : k;

    assign cap_vec[3*k]     = pin_in[PIN];
    assign cap_vec[3*k + 1] = core_out[PIN];
    assign cap_vec[3*k + 2] = core_oe[PIN];

    always_ff @(posedge tck) begin
      if (rst) begin
        drive_out[PIN] <= 1'b0;
        drive_oe[PIN]  <= 1'b0;
      end else if (sel_en && update) begin
        drive_out[PIN] <= q[3*k + 1];
        drive_oe[PIN]  <= q[3*k + 2];
      end
    end
  end

  always_ff @(posedge tck) begin
    if (rst)                    q <= '0;
    else if (sel_en && capture) q <= cap_vec;
    else if (sel_en && shift)   q <= {tdi, q[CHAIN_LEN-1:1]};
  end
endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
  import jtag_dr_pkg::*;
#(
  parameter int         N_PINS            = 4,
  parameter bit         REVERSE_PIN_ORDER = 1'b0,
  parameter logic [3:0]  ID_VERSION       = IDC_VERSION,
  parameter logic [15:0] ID_PART          = IDC_PART,
  parameter logic [10:0] ID_MAKER         = IDC_MAKER,
  localparam int        CHAIN_LEN         = 3 * N_PINS + 1,
  localparam logic [31:0] ID_CODE         = idc_pack(ID_VERSION, ID_PART, ID_MAKER)
) (
  input  logic              tck,
  input  logic              rst,
  input  logic [1:0]        dr_sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] core_out,
  input  logic [N_PINS-1:0] core_oe,
  input  logic              rst_pin_in,
  output logic [N_PINS-1:0] drive_out,
  output logic [N_PINS-1:0] drive_oe
);
  drsel_e               sel;
  logic                 sel_id, sel_bs, sel_pass;
  logic [31:0]          id_q;
  logic                 byp_q;
  logic [CHAIN_LEN-1:0] bs_q;
  logic                 tdo_next;

  assign sel      = drsel_e'(dr_sel);
  assign sel_id   = (sel == DRSEL_IDENT);
  assign sel_bs   = (sel == DRSEL_BOUNDARY);
  assign sel_pass = !sel_id && !sel_bs;

  jtag_idcode_dr #(.WIDTH(32), .CODE(ID_CODE)) u_id (
    .tck(tck), .rst(rst), .sel_en(sel_id), .capture(capture_dr),
    .shift(shift_dr), .tdi(tdi), .q(id_q)
  );

  jtag_pass_dr u_pass (
    .tck(tck), .rst(rst), .sel_en(sel_pass), .capture(capture_dr),
    .shift(shift_dr), .tdi(tdi), .q(byp_q)
  );

  jtag_bscan_chain #(.N_PINS(N_PINS), .REVERSE_PIN_ORDER(REVERSE_PIN_ORDER)) u_bs (
    .tck(tck), .rst(rst), .sel_en(sel_bs), .capture(capture_dr),
    .shift(shift_dr), .update(update_dr), .tdi(tdi),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .rst_pin_in(rst_pin_in), .q(bs_q),
    .drive_out(drive_out), .drive_oe(drive_oe)
  );

  always_comb begin
    unique case (sel)
      DRSEL_IDENT:    tdo_next = id_q[0];
      DRSEL_BOUNDARY: tdo_next = bs_q[0];
      default:        tdo_next = byp_q;
    endcase
  end

  always_ff @(negedge tck) begin
    if (rst) tdo <= 1'b0;
    else     tdo <= tdo_next;
  end
endmodule

// File: rtl/jtag_dr_checker.sv
module jtag_dr_checker
  import jtag_dr_pkg::*;
#(
  parameter int N_PINS = 4
) (
  input logic              tck,
  input logic              rst,
  input logic [1:0]        dr_sel,
  input logic              capture_dr,
  input logic              update_dr,
  input logic [N_PINS-1:0] drive_out,
  input logic [N_PINS-1:0] drive_oe,
  input logic [31:0]       id_q,
  input logic              byp_q
);
  localparam logic [31:0] EXP_ID = idc_pack(IDC_VERSION, IDC_PART, IDC_MAKER);

  // R1: identification capture yields the fixed code
  a_r1_id_capture: assert property (@(posedge tck) disable iff (rst)
    (capture_dr && dr_sel == 2'b00) |=> (id_q == EXP_ID));

  // R3: pass-through register captures zero
  a_r3_pass_zero: assert property (@(posedge tck) disable iff (rst)
    (capture_dr && dr_sel == 2'b01) |=> (byp_q == 1'b0));

  // R4: spare select behaves as pass-through
  a_r4_spare_pass: assert property (@(posedge tck) disable iff (rst)
    (capture_dr && dr_sel == 2'b11) |=> (byp_q == 1'b0));

  // R8: drive latches move only on a boundary update
  a_r8_drive_hold: assert property (@(posedge tck) disable iff (rst)
    !(update_dr && dr_sel == 2'b10) |=> ($stable(drive_out) && $stable(drive_oe)));

  // R11: reset clears the drive latches
  a_r11_reset_clear: assert property (@(posedge tck)
    rst |=> (drive_out == '0 && drive_oe == '0));
endmodule

bind jtag_dr_bank jtag_dr_checker #(.N_PINS(N_PINS)) u_chk (
  .tck(tck), .rst(rst), .dr_sel(dr_sel), .capture_dr(capture_dr),
  .update_dr(update_dr), .drive_out(drive_out), .drive_oe(drive_oe),
  .id_q(id_q), .byp_q(byp_q)
);

// File: tb/jtag_dr_bank_test.sv
module jtag_dr_bank_test;
  localparam int N = 4;
  localparam int L = 3 * N + 1;
  localparam logic [63:0] IDV = 64'h1BA0_0477;

  logic tck = 1'b0, rst = 1'b1;
  logic [1:0] dr_sel = 2'b00;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic [N-1:0] pin_in = '0, core_out = '0, core_oe = '0;
  logic rst_pin_in = 1'b0;
  logic tdo_a, tdo_b;
  logic [N-1:0] dout_a, doe_a, dout_b, doe_b;

  int checks = 0, fails = 0;
  bit mon_on = 1'b0, done = 1'b0;
  string cur_tag = "";
  bit qa[$];
  bit qb[$];

  always #2.5 tck = ~tck;

  jtag_dr_bank #(.N_PINS(N), .REVERSE_PIN_ORDER(1'b0)) uut (
    .tck(tck), .rst(rst), .dr_sel(dr_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo_a),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .rst_pin_in(rst_pin_in), .drive_out(dout_a), .drive_oe(doe_a)
  );

  jtag_dr_bank #(.N_PINS(N), .REVERSE_PIN_ORDER(1'b1)) uut_rev (
    .tck(tck), .rst(rst), .dr_sel(dr_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo_b),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .rst_pin_in(rst_pin_in), .drive_out(dout_b), .drive_oe(doe_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor: pops expected serial bits at each falling edge window
  initial begin
    forever begin
      @(negedge tck);
      #1;
      if (mon_on) begin
        if (qa.size() == 0 || qb.size() == 0) begin
          chk(1'b0, {cur_tag, " queue underflow"}, 64'(qa.size()), 64'd1);
        end else begin
          bit ea, eb;
          ea = qa.pop_front();
          eb = qb.pop_front();
          chk(tdo_a === ea, {cur_tag, " tdo"}, 64'(tdo_a), 64'(ea));
          chk(tdo_b === eb, {cur_tag, " tdo rev"}, 64'(tdo_b), 64'(eb));
        end
      end
    end
  end

  // Driver: one data-register scan, expected stream pushed to the scoreboard
  task automatic scan(input logic [1:0] sel, input int len, input logic [63:0] din,
                      input logic [63:0] ea, input logic [63:0] eb,
                      input bit cap, input bit both, input bit upd, input string tag);
    @(posedge tck); #1;
    dr_sel = sel; capture_dr = cap; shift_dr = both; tdi = din[0];
    @(posedge tck); #1;
    capture_dr = 1'b0; shift_dr = 1'b1; tdi = din[0]; cur_tag = tag;
    for (int i = 0; i < len; i++) begin
      qa.push_back(ea[i]);
      qb.push_back(eb[i]);
    end
    mon_on = 1'b1;
    for (int k = 1; k < len; k++) begin
      @(posedge tck); #1;
      tdi = din[k];
    end
    @(posedge tck); #1;
    shift_dr = 1'b0; mon_on = 1'b0;
    chk(qa.size() == 0 && qb.size() == 0, {tag, " stream length"}, 64'(qa.size()), 64'd0);
    if (upd) begin
      update_dr = 1'b1;
      @(posedge tck); #1;
      update_dr = 1'b0;
    end
  endtask

  function automatic logic [63:0] bs_cap(input bit rev);
    logic [63:0] v = '0;
    for (int k = 0; k < N; k++) begin
      int p = rev ? (N - 1 - k) : k;
      v[3*k]     = pin_in[p];
      v[3*k + 1] = core_out[p];
      v[3*k + 2] = core_oe[p];
    end
    v[3*N] = rst_pin_in;
    return v;
  endfunction

  function automatic logic [N-1:0] drv_exp(input logic [63:0] pat, input bit rev, input bit en);
    logic [N-1:0] r = '0;
    for (int k = 0; k < N; k++) begin
      int p = rev ? (N - 1 - k) : k;
      r[p] = en ? pat[3*k + 2] : pat[3*k + 1];
    end
    return r;
  endfunction

  task automatic check_drive(input logic [63:0] pat, input string tag);
    chk(dout_a === drv_exp(pat, 1'b0, 1'b0), {tag, " drive_out"}, 64'(dout_a), 64'(drv_exp(pat, 1'b0, 1'b0)));
    chk(doe_a  === drv_exp(pat, 1'b0, 1'b1), {tag, " drive_oe"},  64'(doe_a),  64'(drv_exp(pat, 1'b0, 1'b1)));
    chk(dout_b === drv_exp(pat, 1'b1, 1'b0), {tag, " drive_out rev"}, 64'(dout_b), 64'(drv_exp(pat, 1'b1, 1'b0)));
    chk(doe_b  === drv_exp(pat, 1'b1, 1'b1), {tag, " drive_oe rev"},  64'(doe_b),  64'(drv_exp(pat, 1'b1, 1'b1)));
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      chk(1'b0, "watchdog", 64'd0, 64'd1);
      finish_run();
    end
  end

  initial begin
    logic [63:0] d1, p1, q1, c1, bp, pa, pb;
    d1 = 64'h3C3C_00FF;
    p1 = 64'h1B5A;
    q1 = 64'h0A63;
    c1 = 64'h16C9;
    bp = 64'h2D;

    // R11: reset state
    repeat (3) @(posedge tck);
    @(negedge tck); #1;
    chk(tdo_a === 1'b0, "R11 tdo in reset", 64'(tdo_a), 64'd0);
    chk(dout_a === '0 && doe_a === '0, "R11 drive in reset", 64'({dout_a, doe_a}), 64'd0);
    @(posedge tck); #1;
    rst = 1'b0;
    // R2: first falling edge after reset shows identification bit 0
    @(negedge tck); #1;
    chk(tdo_a === 1'b1, "R2 tdo after reset", 64'(tdo_a), 64'd1);

    // R2: shift without capture reads the preloaded code
    scan(2'b00, 32, 64'hA5C3_0F96, IDV, IDV, 1'b0, 1'b0, 1'b0, "R2 id preload");
    // R7: shifted-in data comes back LSB first
    scan(2'b00, 32, 64'h1234_5678, 64'hA5C3_0F96, 64'hA5C3_0F96, 1'b0, 1'b0, 1'b0, "R7 id shift path");
    // R1: capture reloads the code
    scan(2'b00, 32, d1, IDV, IDV, 1'b1, 1'b0, 1'b0, "R1 id capture");

    // R3: pass-through captures 0 then delays tdi by one cycle
    scan(2'b01, 6, bp, {bp[62:0], 1'b0}, {bp[62:0], 1'b0}, 1'b1, 1'b0, 1'b0, "R3 pass capture");
    // R4: spare code acts as pass-through
    scan(2'b11, 6, ~bp, {~bp[62:0], 1'b0}, {~bp[62:0], 1'b0}, 1'b1, 1'b0, 1'b0, "R4 spare select");

    // R5 R6 R9: boundary capture with both pin orders, then update
    pin_in = 4'b1010; core_out = 4'b0110; core_oe = 4'b0011; rst_pin_in = 1'b1;
    pa = bs_cap(1'b0); pb = bs_cap(1'b1);
    scan(2'b10, L, p1, pa, pb, 1'b1, 1'b0, 1'b1, "R5 R6 boundary capture");
    check_drive(p1, "R9 update");

    // R12: other registers untouched by boundary/pass traffic
    scan(2'b01, 4, 64'h5, 64'hA, 64'hA, 1'b1, 1'b0, 1'b0, "R3 pass short");
    scan(2'b10, L, q1, p1, p1, 1'b0, 1'b0, 1'b0, "R12 boundary kept");
    // R8: shifting without update leaves drive values
    check_drive(p1, "R8 hold while shifting");
    scan(2'b00, 32, 64'h0, d1, d1, 1'b0, 1'b0, 1'b0, "R12 id kept");

    // R8: update strobe under a non-boundary select is ignored
    @(posedge tck); #1;
    dr_sel = 2'b00; update_dr = 1'b1;
    @(posedge tck); #1;
    update_dr = 1'b0;
    @(negedge tck); #1;
    check_drive(p1, "R8 update other select");

    // R10: capture and shift together, capture wins
    pin_in = 4'b0101; core_out = 4'b1100; core_oe = 4'b1001; rst_pin_in = 1'b0;
    pa = bs_cap(1'b0); pb = bs_cap(1'b1);
    scan(2'b10, L, c1, pa, pb, 1'b1, 1'b1, 1'b1, "R10 capture over shift");
    check_drive(c1, "R9 second update");

    // R11: mid-run reset
    @(posedge tck); #1;
    rst = 1'b1;
    @(posedge tck); #1;
    @(negedge tck); #1;
    chk(dout_a === '0 && doe_a === '0 && dout_b === '0 && doe_b === '0,
        "R11 drive after reset", 64'({dout_a, doe_a, dout_b, doe_b}), 64'd0);
    chk(tdo_a === 1'b0, "R11 tdo after reset", 64'(tdo_a), 64'd0);
    @(posedge tck); #1;
    rst = 1'b0;
    scan(2'b10, L, 64'h0, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, "R11 boundary cleared");
    scan(2'b00, 32, 64'h0, IDV, IDV, 1'b0, 1'b0, 1'b0, "R2 id after second reset");

    done = 1'b1;
    finish_run();
  end
endmodule